// File: doc/BRIEF.md
# Snake Position and Collision Controller

This block keeps the position of a snake on a tile grid and decides, once per slow movement tick, whether the snake moves, grows or dies. The body is held as two parallel arrays of tile coordinates, one for X and one for Y, with segment 0 as the head. A separate length register says how many of those entries are live.

On a tick while the game is running, the block works out the head's next tile from the stored direction. It checks that tile against the grid edge, against the live body segments as they stand before the move, and against the apple coordinate. If the move is legal, every segment takes the place of the one in front of it and the head steps forward. If the move is not legal, nothing moves and the game ends.

Direction requests arrive as one-cycle pulses from debounced buttons. A request that would turn the snake straight back on itself is dropped. The game leaves its idle state on the first direction pulse, and only a synchronous reset leaves the game-over state. Rendering and apple placement belong to other blocks.

Top module: `snake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block restores its initial state. The length becomes INIT_LEN (3). Segment i is at X = GRID_W/2 − i and Y = GRID_H/2, which is (8,6), (7,6), (6,6) for the defaults. The stored direction becomes right, and `grow`, `collide` and `game_over` are all 0.
- R2: After reset the block is idle: ticks move nothing. The first pulse on any direction input starts the game, and from then on ticks move the snake.
- R3: On each tick while running, if the move is legal, the head moves one tile in the stored direction and every other segment takes the previous position of the segment ahead of it. Up decreases Y, down increases Y, left decreases X and right increases X. Without a tick, nothing moves.
- R4: A direction pulse that is the exact opposite of the direction of the last move is ignored, even when another turn was accepted since that move. Simultaneous pulses resolve as up, then down, then left, then right. A pulse that arrives in the same cycle as a tick steers the following tick.
- R5: When the next head tile equals (`apple_x`, `apple_y`) on a legal move, `grow` is 1 for exactly the one cycle after the tick, and the length increases by one.
- R6: The length never exceeds MAX_LEN (8). Eating at full length still pulses `grow`, but the length stays at MAX_LEN.
- R7: When the next head tile would lie outside the grid (0..GRID_W−1, 0..GRID_H−1), `collide` pulses for one cycle, `game_over` becomes 1 and nothing moves.
- R8: When the next head tile equals any of segments 1 to length−1 as they stand before the move, the block raises `collide` and `game_over` and makes no move, exactly as in R7.
- R9: Once `game_over` is 1, the positions, the length and `game_over` all stay fixed whatever the ticks and direction pulses do, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle movement strobe |
| req_up | input | 1 | Direction pulse: up (Y−1) |
| req_down | input | 1 | Direction pulse: down (Y+1) |
| req_left | input | 1 | Direction pulse: left (X−1) |
| req_right | input | 1 | Direction pulse: right (X+1) |
| apple_x | input | XW | Apple tile X |
| apple_y | input | YW | Apple tile Y |
| seg_x | output | MAX_LEN*XW | Segment X coordinates, segment i at bits [i*XW +: XW] |
| seg_y | output | MAX_LEN*YW | Segment Y coordinates, segment i at bits [i*YW +: YW] |
| length | output | LW | Number of live segments |
| grow | output | 1 | One-cycle pulse after an apple is eaten |
| collide | output | 1 | One-cycle pulse after a wall or body hit |
| game_over | output | 1 | High from a hit until reset |

## Verification
A wrong direction or a wrong shift shows at the ports one cycle after the tick that used it. The head lands on the wrong tile, or segment 1 stops matching the head's previous tile. A reversal that slips past the steering filter drives the head into segment 1 on the next tick, so it shows as a false `collide` within one movement step. A missed or early hit shows the same way: the snake either keeps moving past an edge or a body segment, or freezes one cycle after a legal tick.

// File: rtl/snake_pkg.sv
// Package: shared direction and state types for the snake controller.
// Assumes two-bit encodings; the direction codes are internal only.
package snake_pkg;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_DOWN  = 2'd1,
        DIR_LEFT  = 2'd2,
        DIR_RIGHT = 2'd3
    } dir_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_OVER = 2'd2
    } state_t;

    // Returns the direction pointing the other way.
    function automatic dir_t opposite(input dir_t d);
        case (d)
            DIR_UP:   return DIR_DOWN;
            DIR_DOWN: return DIR_UP;
            DIR_LEFT: return DIR_RIGHT;
            default:  return DIR_LEFT;
        endcase
    endfunction

endpackage

// File: rtl/snake_steer.sv
// Module: snake_steer
// Holds the steering direction and the direction of the last committed move.
// Rejects any request that reverses the last committed move.
// Assumes the request inputs are single-cycle pulses.
module snake_steer
    import snake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic commit,
    input  logic req_up,
    input  logic req_down,
    input  logic req_left,
    input  logic req_right,
    output dir_t dir_o,
    output logic any_req_o
);

    dir_t dir_q;
    dir_t moved_q;
    dir_t pick;
    dir_t last_move;

    // Fixed-priority choice among simultaneous requests.
    always_comb begin
        any_req_o = req_up | req_down | req_left | req_right;
        if (req_up)
            pick = DIR_UP;
        else if (req_down)
            pick = DIR_DOWN;
        else if (req_left)
            pick = DIR_LEFT;
        else
            pick = DIR_RIGHT;
        last_move = commit ? dir_q : moved_q;
    end

    // Direction registers: accept non-reversing requests, record moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= DIR_RIGHT;
            moved_q <= DIR_RIGHT;
        end else begin
            if (enable && any_req_o && pick != opposite(last_move))
                dir_q <= pick;
            if (commit)
                moved_q <= dir_q;
        end
    end

    assign dir_o = dir_q;

    // R4
    no_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_q != opposite(moved_q));

endmodule

// File: rtl/snake_hit.sv
// Module: snake_hit
// Combinational look-ahead: computes the next head tile and flags a wall,
// body or apple match against it. Body compare uses pre-move segments 1..len-1.
// Assumes the segment arrays are packed with segment i at [i*W +: W].
module snake_hit
    import snake_pkg::*;
#(
    parameter int GRID_W  = 16,
    parameter int GRID_H  = 12,
    parameter int MAX_LEN = 8,
    localparam int XW = $clog2(GRID_W),
    localparam int YW = $clog2(GRID_H),
    localparam int LW = $clog2(MAX_LEN + 1)
)(
    input  dir_t                  dir,
    input  logic [MAX_LEN*XW-1:0] seg_x,
    input  logic [MAX_LEN*YW-1:0] seg_y,
    input  logic [LW-1:0]         len,
    input  logic [XW-1:0]         apple_x,
    input  logic [YW-1:0]         apple_y,
    output logic [XW-1:0]         next_x,
    output logic [YW-1:0]         next_y,
    output logic                  wall_o,
    output logic                  body_o,
    output logic                  eat_o
);

    logic [XW-1:0]      hx;
    logic [YW-1:0]      hy;
    logic [MAX_LEN-1:0] match;

    assign hx = seg_x[XW-1:0];
    assign hy = seg_y[YW-1:0];

    // Next head tile and edge test for the stored direction.
    always_comb begin
        next_x = hx;
        next_y = hy;
        wall_o = 1'b0;
        case (dir)
            DIR_UP: begin
                wall_o = (hy == '0);
                next_y = hy - 1'b1;
            end
            DIR_DOWN: begin
                wall_o = (hy == YW'(GRID_H - 1));
                next_y = hy + 1'b1;
            end
            DIR_LEFT: begin
                wall_o = (hx == '0);
                next_x = hx - 1'b1;
            end
            default: begin
                wall_o = (hx == XW'(GRID_W - 1));
                next_x = hx + 1'b1;
            end
        endcase
    end

    assign match[0] = 1'b0;

    // One comparator per live body segment.
    for (genvar i = 1; i < MAX_LEN; i++) begin : g_cmp
        assign match[i] = (LW'(i) < len)
                          && (seg_x[i*XW +: XW] == next_x)
                          && (seg_y[i*YW +: YW] == next_y);
    end

    assign body_o = |match;
    assign eat_o  = (next_x == apple_x) && (next_y == apple_y);

endmodule

// File: rtl/snake_body.sv
// Module: snake_body
// Parallel X/Y coordinate arrays plus a length register. A step shifts every
// segment into its predecessor's slot and loads the new head.
// Assumes MAX_LEN >= 2 and INIT_LEN <= GRID_W/2 + 1.
module snake_body #(
    parameter int GRID_W   = 16,
    parameter int GRID_H   = 12,
    parameter int MAX_LEN  = 8,
    parameter int INIT_LEN = 3,
    localparam int XW = $clog2(GRID_W),
    localparam int YW = $clog2(GRID_H),
    localparam int LW = $clog2(MAX_LEN + 1),
    localparam int HX0 = GRID_W / 2,
    localparam int HY0 = GRID_H / 2
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  grow,
    input  logic [XW-1:0]         head_x,
    input  logic [YW-1:0]         head_y,
    output logic [MAX_LEN*XW-1:0] seg_x_o,
    output logic [MAX_LEN*YW-1:0] seg_y_o,
    output logic [LW-1:0]         len_o
);

    logic [XW-1:0] sx [MAX_LEN];
    logic [YW-1:0] sy [MAX_LEN];
    logic [LW-1:0] len_q;

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_seg
        localparam int OFF = (i < INIT_LEN) ? i : INIT_LEN - 1;
        logic [XW-1:0] src_x;
        logic [YW-1:0] src_y;

        if (i == 0) begin : g_head
            assign src_x = head_x;
            assign src_y = head_y;
        end else begin : g_tail
            assign src_x = sx[i-1];
            assign src_y = sy[i-1];
        end

        // Segment register: restore start position or follow predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sx[i] <= XW'(HX0 - OFF);
                sy[i] <= YW'(HY0);
            end else if (step) begin
                sx[i] <= src_x;
                sy[i] <= src_y;
            end
        end

        assign seg_x_o[i*XW +: XW] = sx[i];
        assign seg_y_o[i*YW +: YW] = sy[i];
    end

    // Length register: grows by one on an eating step, saturating at MAX_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LW'(INIT_LEN);
        else if (step && grow && len_q < LW'(MAX_LEN))
            len_q <= len_q + 1'b1;
    end

    assign len_o = len_q;

    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    assign dx = (sx[0] > sx[1]) ? sx[0] - sx[1] : sx[1] - sx[0];
    assign dy = (sy[0] > sy[1]) ? sy[0] - sy[1] : sy[1] - sy[0];

    // R3
    shift_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (sx[1] == $past(sx[0])) && (sy[1] == $past(sy[0])));

    // R3
    head_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((dx == XW'(1)) && (dy == '0)) || ((dx == '0) && (dy == YW'(1))));

    // R6
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LW'(INIT_LEN)) && (len_q <= LW'(MAX_LEN)));

    // R5
    len_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(len_q));

endmodule

// File: rtl/snake_ctrl.sv
// Module: snake_ctrl (top)
// Game sequencer: idle until the first direction pulse, then moves or ends
// the game on each tick using the look-ahead from snake_hit.
// Assumes tick and the direction inputs are single-cycle pulses in clk.
module snake_ctrl
    import snake_pkg::*;
#(
    parameter int GRID_W   = 16,
    parameter int GRID_H   = 12,
    parameter int MAX_LEN  = 8,
    parameter int INIT_LEN = 3,
    localparam int XW = $clog2(GRID_W),
    localparam int YW = $clog2(GRID_H),
    localparam int LW = $clog2(MAX_LEN + 1)
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  req_up,
    input  logic                  req_down,
    input  logic                  req_left,
    input  logic                  req_right,
    input  logic [XW-1:0]         apple_x,
    input  logic [YW-1:0]         apple_y,
    output logic [MAX_LEN*XW-1:0] seg_x,
    output logic [MAX_LEN*YW-1:0] seg_y,
    output logic [LW-1:0]         length,
    output logic                  grow,
    output logic                  collide,
    output logic                  game_over
);

    state_t        state_q;
    dir_t          dir;
    logic          any_req;
    logic          move;
    logic          hit;
    logic          wall;
    logic          body;
    logic          eat;
    logic [XW-1:0] nx;
    logic [YW-1:0] ny;
    logic          grow_q;
    logic          hit_q;

    snake_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state_q != ST_OVER),
        .commit    (move),
        .req_up    (req_up),
        .req_down  (req_down),
        .req_left  (req_left),
        .req_right (req_right),
        .dir_o     (dir),
        .any_req_o (any_req)
    );

    snake_hit #(
        .GRID_W (GRID_W),
        .GRID_H (GRID_H),
        .MAX_LEN(MAX_LEN)
    ) u_hit (
        .dir    (dir),
        .seg_x  (seg_x),
        .seg_y  (seg_y),
        .len    (length),
        .apple_x(apple_x),
        .apple_y(apple_y),
        .next_x (nx),
        .next_y (ny),
        .wall_o (wall),
        .body_o (body),
        .eat_o  (eat)
    );

    snake_body #(
        .GRID_W  (GRID_W),
        .GRID_H  (GRID_H),
        .MAX_LEN (MAX_LEN),
        .INIT_LEN(INIT_LEN)
    ) u_body (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (move),
        .grow   (eat),
        .head_x (nx),
        .head_y (ny),
        .seg_x_o(seg_x),
        .seg_y_o(seg_y),
        .len_o  (length)
    );

    // Decide this cycle's outcome: a legal move or a fatal hit.
    always_comb begin
        hit  = (state_q == ST_RUN) && tick && (wall || body);
        move = (state_q == ST_RUN) && tick && !wall && !body;
    end

    // Game state and the one-cycle event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grow_q  <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            grow_q <= move && eat;
            hit_q  <= hit;
            case (state_q)
                ST_IDLE: if (any_req) state_q <= ST_RUN;
                ST_RUN:  if (hit)     state_q <= ST_OVER;
                default: state_q <= ST_OVER;
            endcase
        end
    end

    assign grow      = grow_q;
    assign collide   = hit_q;
    assign game_over = (state_q == ST_OVER);

    // R7
    collide_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> game_over);

    // R8
    no_grow_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grow && collide));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        game_over |=> $stable(seg_x) && $stable(seg_y) && $stable(length) && game_over);

    // R2
    idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(seg_x) && $stable(seg_y));

endmodule

// File: tb/tb_snake_ctrl.sv
// Bench: directed scenarios on the default 16x12 grid, MAX_LEN 8, INIT_LEN 3.
module tb_snake_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int XW = 4;
    localparam int YW = 4;
    localparam int ML = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          req_up = 1'b0, req_down = 1'b0, req_left = 1'b0, req_right = 1'b0;
    logic [XW-1:0] apple_x = '0;
    logic [YW-1:0] apple_y = '0;
    logic [ML*XW-1:0] seg_x;
    logic [ML*YW-1:0] seg_y;
    logic [3:0]    length;
    logic          grow, collide, game_over;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_up(req_up), .req_down(req_down), .req_left(req_left), .req_right(req_right),
        .apple_x(apple_x), .apple_y(apple_y),
        .seg_x(seg_x), .seg_y(seg_y), .length(length),
        .grow(grow), .collide(collide), .game_over(game_over)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_seg(input string req, input int i, input int x, input int y);
        chk(req, $sformatf("seg%0d.x", i), int'(seg_x[i*XW +: XW]), x);
        chk(req, $sformatf("seg%0d.y", i), int'(seg_y[i*YW +: YW]), y);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    // d: 0 up, 1 down, 2 left, 3 right
    task automatic press(input int d);
        @(negedge clk);
        req_up = (d == 0); req_down = (d == 1); req_left = (d == 2); req_right = (d == 3);
        @(negedge clk);
        req_up = 0; req_down = 0; req_left = 0; req_right = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "length", length, 3);
        chk_seg("R1", 0, 8, 6);
        chk_seg("R1", 1, 7, 6);
        chk_seg("R1", 2, 6, 6);
        chk("R1", "grow", grow, 0);
        chk("R1", "collide", collide, 0);
        chk("R1", "game_over", game_over, 0);
    endtask

    task automatic t_idle();
        repeat (3) step();
        chk_seg("R2", 0, 8, 6);
        chk("R2", "game_over", game_over, 0);
    endtask

    task automatic t_move_and_turns();
        press(0);
        step();
        chk_seg("R3", 0, 8, 5);
        chk_seg("R3", 1, 8, 6);
        chk_seg("R3", 2, 7, 6);
        repeat (3) @(negedge clk);
        chk_seg("R3", 0, 8, 5);          // no tick, no move
        press(1);                        // reverse of up: ignored
        step();
        chk_seg("R4", 0, 8, 4);
        press(3);                        // right accepted
        press(1);                        // down reverses last move (up): ignored
        step();
        chk_seg("R4", 0, 9, 4);
        chk("R4", "collide", collide, 0);
    endtask

    task automatic t_eat();
        apple_x = 10; apple_y = 4;
        step();
        chk("R5", "grow", grow, 1);
        chk("R5", "length", length, 4);
        chk_seg("R5", 3, 8, 5);
        @(negedge clk);
        chk("R5", "grow after", grow, 0);
        for (int k = 11; k <= 15; k++) begin
            apple_x = XW'(k);
            step();
            chk("R6", "grow", grow, 1);
        end
        chk("R6", "length saturated", length, 8);
        chk_seg("R6", 0, 15, 4);
        chk_seg("R6", 7, 8, 4);
        apple_x = 0; apple_y = 0;
    endtask

    task automatic t_self_hit();
        press(1); step();
        chk_seg("R8", 0, 15, 5);
        press(2); step();
        chk_seg("R8", 0, 14, 5);
        press(0); step();                // into (14,4), a body segment
        chk("R8", "collide", collide, 1);
        chk("R8", "game_over", game_over, 1);
        chk_seg("R8", 0, 14, 5);
        @(negedge clk);
        chk("R8", "collide pulse", collide, 0);
    endtask

    task automatic t_frozen();
        press(2); step(); press(1); step(); step();
        chk_seg("R9", 0, 14, 5);
        chk_seg("R9", 1, 15, 5);
        chk("R9", "length", length, 8);
        chk("R9", "game_over", game_over, 1);
    endtask

    task automatic t_wall();
        do_reset();
        chk_seg("R1", 0, 8, 6);
        chk("R1", "game_over", game_over, 0);
        press(2);                        // starts game, reversal dropped
        step();
        chk_seg("R2", 0, 9, 6);
        repeat (6) step();
        chk_seg("R7", 0, 15, 6);
        chk("R7", "collide before", collide, 0);
        step();
        chk("R7", "collide", collide, 1);
        chk("R7", "game_over", game_over, 1);
        chk_seg("R7", 0, 15, 6);
        chk("R7", "length", length, 3);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_move_and_turns();
        t_eat();
        t_self_hit();
        t_frozen();
        t_wall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule